// File: doc/BRIEF.md
# Steered Direct-Mapped Instruction Filter Cache

This block is a very small instruction cache that sits between an instruction fetch unit and the level-one instruction cache, which it calls the backing cache. Each fetch arrives with a steering bit chosen by logic outside the block. When the bit selects the small cache, the block looks the address up in its direct-mapped array. A hit returns the instruction one cycle after the fetch is accepted. A miss asks the backing cache for the whole line. When the line arrives, the block returns the requested word to the core and writes the line into its array in the same cycle.

When the steering bit selects the backing cache, the fetch bypasses the array. The backing cache supplies the line, the word is returned to the core, and the array is neither read nor written. Lines enter the array only on steered demand misses. There is no prefetching, write path or coherence support. The block keeps one fetch in flight at a time. The backing cache is expected to answer a line request with a single-cycle response pulse. When it answers in the cycle after the request, a miss costs exactly one cycle more than a hit.

Top module: `l0_filter_icache`

## Requirements
- R1: Capacity `CAP_BYTES` (256 or 512) and line size `LINE_BYTES` (8 or 16) are parameters, giving `CAP_BYTES/LINE_BYTES` lines. Byte address bits [1:0] are ignored. The bits from 2 up to log2(LINE_BYTES)-1 select the 32-bit word within a line. The next log2(lines) bits select the single candidate line, and every bit above them forms the tag.
- R2: A steered fetch that hits raises `rsp_valid` with the stored instruction in the cycle after acceptance and issues no backing request.
- R3: A steered miss issues one `fill_req_valid` pulse whose `fill_req_addr` is the fetch address shifted right by log2(LINE_BYTES). In the cycle `fill_rsp_valid` arrives, the block returns the addressed word of `fill_rsp_line` on `rsp_instr` and writes the whole line, word k at bits [32k+31:32k]. A later steered fetch of any word in that line then hits.
- R4: With a backing cache that answers in the cycle after the request, a steered miss responds two cycles after acceptance, one cycle later than a hit.
- R5: With `req_use_l0` = 0 the fetch always goes to the backing cache, even when the line is resident, and responds with the same timing as a miss. It leaves the array unchanged: resident lines still hit and the bypassed line is not brought in.
- R6: Reset clears every line's valid bit, so the first steered fetch to each line misses.
- R7: A fill replaces the line at its index unconditionally. After a fill with a different tag, a fetch to the evicted address misses.
- R8: `req_ready` is high only when no fetch is in flight. While a fetch is outstanding, `req_ready`, `rsp_valid` and `fill_req_valid` are never high together. After reset `req_ready` is 1 and the other two are 0.
- R9: All words of a line and all four byte offsets within a word return the same instruction as the word-aligned address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously by the clock domain |
| req_valid | input | 1 | Fetch request valid |
| req_ready | output | 1 | Block can accept a fetch |
| req_addr | input | ADDR_W | Fetch byte address |
| req_use_l0 | input | 1 | Steering: 1 = use the small cache, 0 = bypass to the backing cache |
| rsp_valid | output | 1 | Instruction response valid (one-cycle pulse) |
| rsp_instr | output | 32 | Returned instruction |
| fill_req_valid | output | 1 | Line request to the backing cache (one-cycle pulse) |
| fill_req_addr | input/output | ADDR_W-log2(LINE_BYTES) | See below |
| fill_rsp_valid | input | 1 | Backing line response valid |
| fill_rsp_line | input | 8*LINE_BYTES | Backing line data, word 0 in the low bits |

The `fill_req_addr` row above has the wrong direction. The correct row, in port-list order, is:

| Port | Direction | Width | Description |
|---|---|---|---|
| fill_req_addr | output | ADDR_W-log2(LINE_BYTES) | Line address requested from the backing cache |

## Verification
The bench builds the block with 256 bytes, 8-byte lines and a 12-bit address, giving 32 lines, 2 words per line and 16 tags per index. At that size it can reach every line, every word and byte offset, and every tag alias of each index. Reference instructions are a function of the word address, and the backing model answers one cycle after each request. Latency is counted at the ports, so hit, miss, bypass, eviction and post-reset behaviour all show up in cycle counts and backing-request counts.

// File: rtl/l0fc_pkg.sv
package l0fc_pkg;
  // Fetch sequencing phases
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_PROBE = 2'd1,
    PH_FILL = 2'd2
  } l0fc_phase_e;

  localparam int unsigned INSTR_W = 32;
  localparam int unsigned INSTR_BYTES = INSTR_W / 8;
endpackage

// File: rtl/l0fc_tag_store.sv
module l0fc_tag_store #(
  parameter int unsigned LINES = 32,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] rd_idx,
  input  logic [TAG_W-1:0] rd_tag,
  output logic             rd_hit,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [TAG_W-1:0] wr_tag
);
  logic [LINES-1:0] vld_q;
  logic [LINES-1:0] vld_d;
  logic [TAG_W-1:0] tag_q [LINES];

  always_comb begin
    vld_d = vld_q;
    if (wr_en) vld_d[wr_idx] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= '0;
    else        vld_q <= vld_d;
  end

  for (genvar g = 0; g < LINES; g++) begin : g_tag
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (sel_w) tag_q[g] <= wr_tag;
    end
  end

  assign rd_hit = vld_q[rd_idx] && (tag_q[rd_idx] == rd_tag);

  // After a fill the written line is valid
  assert_fill_marks_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> vld_q[$past(wr_idx)]);

  // Reading back the tag just written hits
  assert_fill_then_hit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == rd_idx && wr_tag == rd_tag) |=>
      ($stable(rd_idx) && $stable(rd_tag)) ? rd_hit : 1'b1);
endmodule

// File: rtl/l0fc_data_store.sv
module l0fc_data_store #(
  parameter int unsigned LINES = 32,
  parameter int unsigned IDX_W = 5,
  parameter int unsigned LINE_W = 64
) (
  input  logic              clk,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [LINE_W-1:0] rd_line,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [LINE_W-1:0] wr_line
);
  logic [LINE_W-1:0] line_q [LINES];

  // Data lines carry no reset; validity lives in the tag store
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic sel_w;
    assign sel_w = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (sel_w) line_q[g] <= wr_line;
    end
  end

  assign rd_line = line_q[rd_idx];
endmodule

// File: rtl/l0fc_ctrl.sv
module l0fc_ctrl
  import l0fc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic req_use_l0,
  output logic req_ready,
  output logic accept,
  input  logic hit,
  input  logic fill_rsp_valid,
  output logic fill_req_valid,
  output logic rsp_hit,
  output logic rsp_fill,
  output logic line_wr,
  output logic steer_q
);
  l0fc_phase_e phase_q, phase_d;
  logic steer_d;

  always_comb begin
    phase_d        = phase_q;
    steer_d        = steer_q;
    req_ready      = 1'b0;
    accept         = 1'b0;
    fill_req_valid = 1'b0;
    rsp_hit        = 1'b0;
    rsp_fill       = 1'b0;
    line_wr        = 1'b0;
    unique case (phase_q)
      PH_IDLE: begin
        req_ready = 1'b1;
        if (req_valid) begin
          accept  = 1'b1;
          steer_d = req_use_l0;
          phase_d = PH_PROBE;
        end
      end
      PH_PROBE: begin
        if (steer_q && hit) begin
          rsp_hit = 1'b1;
          phase_d = PH_IDLE;
        end else begin
          fill_req_valid = 1'b1;
          phase_d        = PH_FILL;
        end
      end
      PH_FILL: begin
        if (fill_rsp_valid) begin
          rsp_fill = 1'b1;
          line_wr  = steer_q;
          phase_d  = PH_IDLE;
        end
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      steer_q <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (accept) steer_q <= steer_d;
    end
  end

  assert_single_phase_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, rsp_hit | rsp_fill, fill_req_valid}));

  assert_bypass_to_backing_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !req_use_l0) |=> fill_req_valid);
endmodule

// File: rtl/l0_filter_icache.sv
module l0_filter_icache
  import l0fc_pkg::*;
#(
  parameter int unsigned ADDR_W     = 12,
  parameter int unsigned CAP_BYTES  = 256,
  parameter int unsigned LINE_BYTES = 8,
  localparam int unsigned LOFF_W    = $clog2(LINE_BYTES),
  localparam int unsigned LINE_W    = 8 * LINE_BYTES
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     req_valid,
  output logic                     req_ready,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic                     req_use_l0,
  output logic                     rsp_valid,
  output logic [INSTR_W-1:0]       rsp_instr,
  output logic                     fill_req_valid,
  output logic [ADDR_W-LOFF_W-1:0] fill_req_addr,
  input  logic                     fill_rsp_valid,
  input  logic [LINE_W-1:0]        fill_rsp_line
);
  localparam int unsigned LINES  = CAP_BYTES / LINE_BYTES;
  localparam int unsigned WORDS  = LINE_BYTES / INSTR_BYTES;
  localparam int unsigned WOFF_W = LOFF_W - 2;
  localparam int unsigned IDX_W  = $clog2(LINES);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - LOFF_W;

  logic              accept, hit, rsp_hit, rsp_fill, line_wr, steer_q;
  logic [ADDR_W-3:0] waddr_q;
  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WOFF_W-1:0] woff;
  logic [LINE_W-1:0] arr_line;
  logic [INSTR_W-1:0] hit_word, fill_word;
  logic [1:0]        unused_byte_lsb;

  assign unused_byte_lsb = req_addr[1:0];

  // Captured word address of the fetch in flight
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      waddr_q <= '0;
    else if (accept) waddr_q <= req_addr[ADDR_W-1:2];
  end

  assign woff = waddr_q[WOFF_W-1:0];
  assign idx  = waddr_q[WOFF_W +: IDX_W];
  assign tag  = waddr_q[ADDR_W-3 -: TAG_W];

  l0fc_ctrl u_ctrl (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_use_l0     (req_use_l0),
    .req_ready      (req_ready),
    .accept         (accept),
    .hit            (hit),
    .fill_rsp_valid (fill_rsp_valid),
    .fill_req_valid (fill_req_valid),
    .rsp_hit        (rsp_hit),
    .rsp_fill       (rsp_fill),
    .line_wr        (line_wr),
    .steer_q        (steer_q)
  );

  l0fc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
    .clk    (clk),
    .rst_n  (rst_n),
    .rd_idx (idx),
    .rd_tag (tag),
    .rd_hit (hit),
    .wr_en  (line_wr),
    .wr_idx (idx),
    .wr_tag (tag)
  );

  l0fc_data_store #(.LINES(LINES), .IDX_W(IDX_W), .LINE_W(LINE_W)) u_data (
    .clk     (clk),
    .rd_idx  (idx),
    .rd_line (arr_line),
    .wr_en   (line_wr),
    .wr_idx  (idx),
    .wr_line (fill_rsp_line)
  );

  // Word select from either the array line or the incoming fill line
  always_comb begin
    hit_word  = '0;
    fill_word = '0;
    for (int w = 0; w < int'(WORDS); w++) begin
      if (woff == WOFF_W'(w)) begin
        hit_word  = arr_line[w*INSTR_W +: INSTR_W];
        fill_word = fill_rsp_line[w*INSTR_W +: INSTR_W];
      end
    end
  end

  assign rsp_valid     = rsp_hit | rsp_fill;
  assign rsp_instr     = rsp_fill ? fill_word : hit_word;
  assign fill_req_addr = waddr_q[ADDR_W-3 -: (ADDR_W-LOFF_W)];

  // A steered probe that hits answers at once and never goes to the backing cache
  assert_hit_no_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (steer_q && hit && !req_ready && !fill_rsp_valid && $past(accept)) |->
      (rsp_valid && !fill_req_valid));

  // A fill response after a request completes the fetch in that cycle
  assert_fill_forwards_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_req_valid ##1 fill_rsp_valid) |-> rsp_valid);

  // Bypassed fetches never write the array
  assert_bypass_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !steer_q) |=> $stable(hit) || $changed(waddr_q) || $past(accept));
endmodule

// File: tb/l0_filter_icache_tb_top.sv
module l0_filter_icache_tb_top;
  localparam int AW = 12;
  localparam int CAP = 256;
  localparam int LB = 8;
  localparam int LINES = CAP / LB;
  localparam int WORDS = LB / 4;
  localparam int TAGS = (1 << AW) / CAP;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_use_l0, rsp_valid, fill_req_valid, fill_rsp_valid;
  logic [AW-1:0] req_addr;
  logic [31:0] rsp_instr;
  logic [AW-4:0] fill_req_addr;
  logic [8*LB-1:0] fill_rsp_line;

  int nvec = 0;
  int nbad = 0;
  int nfill = 0;
  logic [AW-4:0] bk_addr, last_fill;
  bit done = 0;

  always #2.5 clk = ~clk;

  l0_filter_icache #(.ADDR_W(AW), .CAP_BYTES(CAP), .LINE_BYTES(LB)) dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_use_l0(req_use_l0), .rsp_valid(rsp_valid),
    .rsp_instr(rsp_instr), .fill_req_valid(fill_req_valid),
    .fill_req_addr(fill_req_addr), .fill_rsp_valid(fill_rsp_valid),
    .fill_rsp_line(fill_rsp_line));

  function automatic logic [31:0] ref_word(input int waddr);
    return 32'(waddr) * 32'h9E3779B1 + 32'h0135_7ACE;
  endfunction

  // Backing cache model: answers one cycle after each request
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) fill_rsp_valid <= 1'b0;
    else begin
      fill_rsp_valid <= fill_req_valid;
      if (fill_req_valid) begin
        bk_addr   <= fill_req_addr;
        last_fill <= fill_req_addr;
        nfill     <= nfill + 1;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < WORDS; k++)
      fill_rsp_line[32*k +: 32] = ref_word(int'(bk_addr) * WORDS + k);
  end

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  // Issue one fetch and check latency, data and backing traffic
  task automatic fetch(input int a, input bit steer, input int exp_lat, input string rq);
    int lat;
    int f0;
    @(negedge clk);
    chk(req_ready == 1'b1, {rq, " R8 ready"}, 32'(req_ready), 1);
    req_valid = 1'b1; req_addr = AW'(a); req_use_l0 = steer;
    f0 = nfill;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    lat = 1;
    while (!rsp_valid && lat < 8) begin
      chk(req_ready == 1'b0, {rq, " R8 busy"}, 32'(req_ready), 0);
      @(negedge clk);
      lat++;
    end
    chk(lat == exp_lat, {rq, " latency"}, 32'(lat), 32'(exp_lat));
    chk(rsp_instr == ref_word(a / 4), {rq, " data"}, rsp_instr, ref_word(a / 4));
    chk((nfill - f0) == (exp_lat == 1 ? 0 : 1), {rq, " backing requests"},
        32'(nfill - f0), (exp_lat == 1 ? 0 : 1));
    if (exp_lat != 1)
      chk(last_fill == AW'(a / LB), {rq, " R3 line addr"}, 32'(last_fill), 32'(a / LB));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nbad++;
      nvec++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_use_l0 = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready == 1'b1, "R8 reset ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R8 reset rsp", 32'(rsp_valid), 0);
    chk(fill_req_valid == 1'b0, "R8 reset fill", 32'(fill_req_valid), 0);

    // R6/R4: cold array, every line misses first
    for (int l = 0; l < LINES; l++) fetch(l * LB, 1'b1, 2, "R6 cold miss");
    // R2/R9: every word and byte offset now hits
    for (int l = 0; l < LINES; l++)
      for (int w = 0; w < WORDS; w++)
        for (int b = 0; b < 4; b++) fetch(l * LB + w * 4 + b, 1'b1, 1, "R2 R9 hit");

    // R5: bypass of a conflicting address leaves the array untouched
    fetch(5 * CAP + 3 * LB + 4, 1'b0, 2, "R5 bypass");
    fetch(3 * LB, 1'b1, 1, "R5 resident kept");
    fetch(5 * CAP + 3 * LB + 4, 1'b1, 2, "R5 not filled");
    fetch(3 * LB, 1'b1, 2, "R7 evicted");

    // R1/R7/R3: every tag alias of every index
    for (int t = 1; t < TAGS; t++)
      for (int l = 0; l < LINES; l++) begin
        fetch(t * CAP + l * LB + 4, 1'b1, 2, "R1 R7 alias miss");
        fetch(t * CAP + l * LB, 1'b1, 1, "R3 whole line");
      end

    // R5: bypass even when resident
    for (int l = 0; l < LINES; l++) begin
      fetch((TAGS - 1) * CAP + l * LB, 1'b0, 2, "R5 bypass resident");
      fetch((TAGS - 1) * CAP + l * LB, 1'b1, 1, "R5 still resident");
    end

    // R6: reset mid-run drops resident lines
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    for (int l = 0; l < LINES; l++) fetch((TAGS - 1) * CAP + l * LB, 1'b1, 2, "R6 after reset");

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end
endmodule